// File: doc/BRIEF.md
# Dual-Role SPI Channel with Buffered Data Path

This block is one SPI channel that works either as the clock-driving master or as a selected slave. Software reaches it through four 16-bit words: status, transmit data, receive data and control. A byte written to the transmit word sits in a one-deep transmit buffer until the shifter takes it. Each finished 8-bit frame is copied from the shifter into a one-deep receive buffer. A level interrupt request tells an external interrupt controller that the receive buffer holds data. Software can then test the full flag in the status word to confirm the cause.

The shifter is a three-state machine. `ST_IDLE` waits. It takes the transition IDLE→MSHIFT when the channel is enabled in master mode with the transmit buffer full. It takes IDLE→SSHIFT when the channel is enabled in slave mode and the synchronised select input is low. `ST_MSHIFT` runs the internal SCLK divider for sixteen half periods. It returns MSHIFT→IDLE on the eighth trailing edge, or at once if enable or master mode drops. `ST_SSHIFT` follows external SCLK edges seen through two-flop synchronisers. It stays there across frames while select stays low, reloading the shifter from the transmit buffer on each eighth trailing edge. It returns SSHIFT→IDLE when select rises, which aborts a partial frame, or when enable or slave mode drops.

Status bit 2 means "busy" in master mode and "select is low" in slave mode.

Top module: `spi_chan`

## Requirements
- R1: After reset the status word reads 0x0001, the control word reads 0x0000, `irq` is 0 and `sclk_o` is 0.
- R2: The register word is selected by `reg_addr[2:1]`: 0 is status, 1 is transmit, 2 is receive and 3 is control. The control fields are: bit 0 enable, bit 1 master (1) or slave (0), bit 2 CPOL, bit 3 CPHA, bit 4 receive interrupt enable, and bits 7:5 divider n, giving an SCLK half period of 2^n clocks. Control reads back bits 7:0, and bits 15:8 read 0.
- R3: A write to the transmit word makes status bit 0 (transmit empty) read 0. In master mode with the shifter idle, the byte moves to the shifter on the next clock and bit 0 reads 1 again.
- R4: In master mode status bit 2 reads 1 from the load cycle for exactly 16·2^n cycles, then reads 0.
- R5: In master mode `sclk_o` rests at CPOL and changes level every 2^n clocks, giving 8 pulses per frame.
- R6: Data leaves MSB first on `sdo`. With CPHA=0 each bit is valid from the load or the previous trailing edge. With CPHA=1 each bit changes on the leading edge.
- R7: At the end of a frame the received byte sits in the receive word and status bit 1 reads 1. Reading the receive word clears bit 1.
- R8: A frame that ends while bit 1 is already 1 replaces the receive byte, and bit 1 stays 1.
- R9: `irq` is 1 exactly while status bit 1 is 1 and control bit 4 is 1.
- R10: Status bits 15:3 read 0, and writes to the status word have no effect.
- R11: In slave mode status bit 2 reads 1 while `ss_n` is low and 0 while it is high, after a two-clock synchroniser.
- R12: In slave mode with `ss_n` low, the transmit byte is loaded when select falls. Eight bits are exchanged on external SCLK edges in the chosen CPOL/CPHA mode, and the received byte goes to the receive word.
- R13: When `ss_n` rises in slave mode before 8 bits have arrived, the frame is dropped: bit 1 and the receive word keep their values, and the next frame starts from bit 7.
- R14: A transmit byte written while a master frame runs is loaded one clock after that frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Byte offset of the register word; bits 2:1 pick the word |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of the receive word clears the full flag |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed word |
| irq | output | 1 | Receive-full interrupt request |
| sclk_o | output | 1 | SCLK driven in master mode |
| sclk_i | input | 1 | SCLK received in slave mode |
| ss_n | input | 1 | Slave select, active low |
| sdi | input | 1 | Serial data in (MISO as master, MOSI as slave) |
| sdo | output | 1 | Serial data out (MOSI as master, MISO as slave) |

## Verification
Master frames run under all four CPOL/CPHA combinations and divider values 0, 1 and 2, with `sdi` looped back either true or inverted. This separates a wrong clock phase or divider, which shows up in the per-clock SCLK and busy comparison, from a wrong sample edge or bit order, which shows up in the received byte against the sent one. Frames ended without a read, and a byte written mid-frame, separate the overwrite rule and the one-clock reload gap from the plain path. Slave frames driven by a bench master in two modes are checked bit by bit on `sdo`. An aborted 4-bit frame, followed by a clean frame, shows that a partial frame neither lands in the receive word nor leaves a stale bit count behind.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MSHIFT = 2'd1,
        ST_SSHIFT = 2'd2
    } spi_state_e;

    typedef struct packed {
        logic [2:0] div;
        logic       rie;
        logic       cpha;
        logic       cpol;
        logic       master;
        logic       en;
    } spi_ctrl_t;

    localparam logic [1:0] W_STAT = 2'd0;
    localparam logic [1:0] W_TXD  = 2'd1;
    localparam logic [1:0] W_RXD  = 2'd2;
    localparam logic [1:0] W_CTRL = 2'd3;

endpackage

// File: rtl/spi_chan_clkgen.sv
module spi_chan_clkgen #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic             cpol,
    output logic             lead,
    output logic             trail,
    output logic             sclk
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_m1;
    logic             phase_q;
    logic             tick;

    assign half_m1 = (CNT_W'(1) << div) - CNT_W'(1);
    assign tick    = run && (cnt_q == half_m1);
    assign lead    = tick && !phase_q;
    assign trail   = tick && phase_q;
    assign sclk    = cpol ^ (phase_q && run);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (!run) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (tick) begin
            cnt_q   <= '0;
            phase_q <= !phase_q;
        end else begin
            cnt_q   <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/spi_chan_sedge.sv
module spi_chan_sedge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sdi,
    input  logic ss_n,
    input  logic cpol,
    output logic ss_low,
    output logic sdi_s,
    output logic lead,
    output logic trail
);
    logic [1:0] ss_q;
    logic [1:0] sclk_q;
    logic [1:0] sdi_q;
    logic       lvl_q;
    logic       lvl;

    assign lvl    = sclk_q[1] ^ cpol;
    assign lead   = lvl && !lvl_q;
    assign trail  = !lvl && lvl_q;
    assign ss_low = !ss_q[1];
    assign sdi_s  = sdi_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_q   <= 2'b11;
            sclk_q <= 2'b00;
            sdi_q  <= 2'b00;
            lvl_q  <= 1'b0;
        end else begin
            ss_q   <= {ss_q[0], ss_n};
            sclk_q <= {sclk_q[0], sclk_i};
            sdi_q  <= {sdi_q[0], sdi};
            lvl_q  <= lvl;
        end
    end
endmodule

// File: rtl/spi_chan_shift.sv
module spi_chan_shift
    import spi_chan_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  spi_ctrl_t          ctrl,
    input  logic               tx_full,
    input  logic [FRAME_W-1:0] tx_buf,
    input  logic               m_lead,
    input  logic               m_trail,
    input  logic               s_lead,
    input  logic               s_trail,
    input  logic               ss_low,
    input  logic               sdi_m,
    input  logic               sdi_s,
    output spi_state_e         state,
    output logic               load,
    output logic               frame_done,
    output logic [FRAME_W-1:0] rx_word,
    output logic               sdo
);
    localparam int BIT_W = $clog2(FRAME_W);
    localparam logic [BIT_W-1:0] LAST = BIT_W'(FRAME_W - 1);

    spi_state_e         state_q, state_d;
    logic [FRAME_W-1:0] sh_q;
    logic [BIT_W-1:0]   bit_q;
    logic               samp_q, sdo_q;
    logic               in_m, in_s, lead, trail, sdi_sel, shift_in;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl.en && ctrl.master && tx_full)     state_d = ST_MSHIFT;
                else if (ctrl.en && !ctrl.master && ss_low) state_d = ST_SSHIFT;
            end
            ST_MSHIFT: begin
                if (!ctrl.en || !ctrl.master || (m_trail && bit_q == LAST))
                    state_d = ST_IDLE;
            end
            ST_SSHIFT: begin
                if (!ctrl.en || ctrl.master || !ss_low) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_m       = (state_q == ST_MSHIFT);
        in_s       = (state_q == ST_SSHIFT) && (state_d == ST_SSHIFT);
        lead       = in_m ? m_lead  : (in_s && s_lead);
        trail      = in_m ? m_trail : (in_s && s_trail);
        sdi_sel    = ctrl.master ? sdi_m : sdi_s;
        shift_in   = ctrl.cpha ? sdi_sel : samp_q;
        rx_word    = {sh_q[FRAME_W-2:0], shift_in};
        frame_done = trail && (bit_q == LAST) && (in_s || (ctrl.en && ctrl.master));
        load       = ((state_q == ST_IDLE) && (state_d != ST_IDLE)) || (in_s && frame_done);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            bit_q  <= '0;
            samp_q <= 1'b0;
            sdo_q  <= 1'b0;
        end else if (load) begin
            sh_q   <= tx_buf;
            sdo_q  <= tx_buf[FRAME_W-1];
            bit_q  <= '0;
        end else begin
            if (lead) begin
                if (!ctrl.cpha) samp_q <= sdi_sel;
                else            sdo_q  <= sh_q[FRAME_W-1];
            end
            if (trail) begin
                sh_q  <= rx_word;
                bit_q <= bit_q + BIT_W'(1);
                if (!ctrl.cpha) sdo_q <= sh_q[FRAME_W-2];
            end
        end
    end

    assign state = state_q;
    assign sdo   = sdo_q;
endmodule

// File: rtl/spi_chan.sv
module spi_chan
    import spi_chan_pkg::*;
#(
    parameter int FRAME_W = 8,
    parameter int DIV_W   = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq,
    output logic        sclk_o,
    input  logic        sclk_i,
    input  logic        ss_n,
    input  logic        sdi,
    output logic        sdo
);
    localparam int CTRL_W = $bits(spi_ctrl_t);

    spi_ctrl_t          ctrl_q;
    logic [FRAME_W-1:0] tx_buf_q, rx_buf_q, rx_word;
    logic               tx_full, rx_full;
    logic               m_lead, m_trail, s_lead, s_trail, ss_low, sdi_s;
    logic               load, frame_done, rd_rx, stat_b2;
    logic [1:0]         widx;
    spi_state_e         st;
    logic               unused_bits;

    assign widx        = reg_addr[2:1];
    assign rd_rx       = reg_rd && (widx == W_RXD);
    assign unused_bits = ^{reg_addr[0], reg_wdata[15:CTRL_W]};

    spi_chan_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(st == ST_MSHIFT), .div(ctrl_q.div),
        .cpol(ctrl_q.cpol), .lead(m_lead), .trail(m_trail), .sclk(sclk_o)
    );

    spi_chan_sedge u_sedge (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdi(sdi), .ss_n(ss_n),
        .cpol(ctrl_q.cpol), .ss_low(ss_low), .sdi_s(sdi_s), .lead(s_lead), .trail(s_trail)
    );

    spi_chan_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .tx_full(tx_full), .tx_buf(tx_buf_q),
        .m_lead(m_lead), .m_trail(m_trail), .s_lead(s_lead), .s_trail(s_trail),
        .ss_low(ss_low), .sdi_m(sdi), .sdi_s(sdi_s), .state(st), .load(load),
        .frame_done(frame_done), .rx_word(rx_word), .sdo(sdo)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            tx_buf_q <= '0;
            tx_full  <= 1'b0;
            rx_buf_q <= '0;
            rx_full  <= 1'b0;
        end else begin
            if (reg_wr && widx == W_CTRL) ctrl_q <= spi_ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (reg_wr && widx == W_TXD) begin
                tx_buf_q <= reg_wdata[FRAME_W-1:0];
                tx_full  <= 1'b1;
            end else if (load) begin
                tx_full  <= 1'b0;
            end
            if (frame_done) begin
                rx_buf_q <= rx_word;
                rx_full  <= 1'b1;
            end else if (rd_rx) begin
                rx_full  <= 1'b0;
            end
        end
    end

    assign stat_b2 = ctrl_q.master ? (st == ST_MSHIFT) : ss_low;
    assign irq     = rx_full && ctrl_q.rie;

    always_comb begin
        unique case (widx)
            W_STAT:  reg_rdata = {13'd0, stat_b2, rx_full, !tx_full};
            W_TXD:   reg_rdata = 16'(tx_buf_q);
            W_RXD:   reg_rdata = 16'(rx_buf_q);
            default: reg_rdata = 16'(ctrl_q);
        endcase
    end
endmodule

// File: rtl/spi_chan_chk.sv
module spi_chan_chk
    import spi_chan_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input spi_state_e st,
    input logic       tx_full,
    input logic       rx_full,
    input logic       frame_done,
    input logic       irq,
    input logic       rie,
    input logic       sclk_o,
    input logic       cpol,
    input logic       en,
    input logic       master,
    input logic       rd_rx,
    input logic       ss_low
);
    p_load_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && tx_full && en && master) |=> (st == ST_MSHIFT));

    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MSHIFT && !frame_done && en && master) |=> (st == ST_MSHIFT));

    p_sclk_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_MSHIFT) |-> (sclk_o == cpol));

    p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && !frame_done) |=> !rx_full);

    p_full_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> rx_full);

    p_irq_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rie) |=> irq);

    p_abort_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SSHIFT && !ss_low) |=> (st != ST_SSHIFT && !$rose(rx_full)));
endmodule

bind spi_chan spi_chan_chk u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .tx_full(tx_full), .rx_full(rx_full),
    .frame_done(frame_done), .irq(irq), .rie(ctrl_q.rie), .sclk_o(sclk_o),
    .cpol(ctrl_q.cpol), .en(ctrl_q.en), .master(ctrl_q.master), .rd_rx(rd_rx),
    .ss_low(ss_low)
);

// File: tb/test_spi_chan.sv
`timescale 1ns/1ps
module test_spi_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        irq, sclk_o, sdo;
    logic        sclk_i = 1'b0, ss_n = 1'b1, sdi_drv = 1'b0;
    logic        lb_on = 1'b0, lb_inv = 1'b0;
    wire         sdi = lb_on ? (sdo ^ lb_inv) : sdi_drv;

    int checks = 0, errors = 0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    spi_chan i_spi_chan (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sclk_o(sclk_o),
        .sclk_i(sclk_i), .ss_n(ss_n), .sdi(sdi), .sdo(sdo)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural master-mode reference model
    int m_c, m_div, m_txb, m_shift, m_rx;
    bit m_busy, m_txf, m_rxf, m_en, m_master, m_cpol, m_cpha, m_rie, m_fin;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_c = 0; m_div = 0; m_txb = 0; m_shift = 0; m_rx = 0;
            m_busy = 0; m_txf = 0; m_rxf = 0; m_en = 0; m_master = 0;
            m_cpol = 0; m_cpha = 0; m_rie = 0;
        end else begin
            m_fin = 0;
            if (m_busy) begin
                m_c++;
                if (m_c == 16 * (1 << m_div)) begin
                    m_busy = 0; m_rxf = 1; m_fin = 1;
                    m_rx = m_shift ^ (lb_inv ? 8'hFF : 8'h00);
                end
            end else if (m_txf && m_en && m_master) begin
                m_busy = 1; m_c = 0; m_txf = 0; m_shift = m_txb;
            end
            if (reg_wr && reg_addr[2:1] == 2'd1) begin m_txb = reg_wdata[7:0]; m_txf = 1; end
            if (reg_wr && reg_addr[2:1] == 2'd3) begin
                m_en = reg_wdata[0]; m_master = reg_wdata[1]; m_cpol = reg_wdata[2];
                m_cpha = reg_wdata[3]; m_rie = reg_wdata[4]; m_div = int'(reg_wdata[7:5]);
            end
            if (reg_rd && reg_addr[2:1] == 2'd2 && !m_fin) m_rxf = 0;
        end
    end

    // per-clock comparison against the model
    always @(posedge clk) begin
        #1;
        if (cmp_on && rst_n) begin
            int h, bidx;
            bit es, eo;
            h  = 1 << m_div;
            es = m_busy ? (m_cpol ^ ((m_c / h) % 2 == 1)) : m_cpol;
            check(sclk_o == es, "R5 sclk", int'(sclk_o), int'(es));
            check(irq == (m_rxf && m_rie), "R9 irq", int'(irq), int'(m_rxf && m_rie));
            if (reg_addr == 3'd0) begin
                check(reg_rdata[0] == !m_txf, "R3 tx empty", int'(reg_rdata[0]), int'(!m_txf));
                check(reg_rdata[1] == m_rxf, "R7 rx full", int'(reg_rdata[1]), int'(m_rxf));
                check(reg_rdata[2] == m_busy, "R4 busy", int'(reg_rdata[2]), int'(m_busy));
                check(reg_rdata[15:3] == 13'd0, "R10 reserved", int'(reg_rdata[15:3]), 0);
            end
            if (m_busy && (!m_cpha || m_c >= h)) begin
                bidx = m_cpha ? 7 - (m_c - h) / (2 * h) : 7 - m_c / (2 * h);
                eo = m_shift[bidx];
                check(sdo == eo, "R6 sdo bit", int'(sdo), int'(eo));
            end
        end
    end

    task automatic bus_write(input logic [1:0] idx, input logic [15:0] d);
        @(negedge clk);
        reg_addr = {idx, 1'b0}; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd0;
    endtask

    task automatic bus_read(input logic [1:0] idx, output logic [15:0] d);
        @(negedge clk);
        reg_addr = {idx, 1'b0}; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; reg_addr = 3'd0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_master_idle();
        while (m_busy || m_txf) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic master_frame(input bit cpol, input bit cpha, input int div, input bit rie,
                                input logic [7:0] d, input bit inv, input bit do_read);
        logic [15:0] v;
        logic [7:0]  exp;
        exp = d ^ (inv ? 8'hFF : 8'h00);
        lb_inv = inv;
        bus_write(2'd3, {8'd0, 3'(div), rie, cpha, cpol, 1'b1, 1'b1});
        bus_write(2'd1, {8'd0, d});
        wait_master_idle();
        bus_read(2'd0, v);
        check(v[1] == 1'b1, "R7 full after frame", int'(v[1]), 1);
        check(irq == rie, "R9 irq after frame", int'(irq), int'(rie));
        if (do_read) begin
            bus_read(2'd2, v);
            check(v == {8'd0, exp}, "R7 rx data", int'(v), int'(exp));
            bus_read(2'd0, v);
            check(v[1] == 1'b0, "R7 cleared by read", int'(v[1]), 0);
            check(irq == 1'b0, "R9 irq cleared", int'(irq), 0);
        end
    endtask

    localparam int HS = 8;

    task automatic slave_frame(input bit cpol, input bit cpha, input logic [7:0] txv,
                               input logic [7:0] rxv, input int nbits);
        logic [15:0] v;
        sclk_i = cpol;
        ss_n = 1'b0;
        repeat (6) @(negedge clk);
        bus_read(2'd0, v);
        check(v[2] == 1'b1, "R11 select low seen", int'(v[2]), 1);
        for (int b = 7; b > 7 - nbits; b--) begin
            if (!cpha) begin
                sdi_drv = rxv[b];
                repeat (HS) @(negedge clk);
                check(sdo == txv[b], "R12 slave sdo cpha0", int'(sdo), int'(txv[b]));
                sclk_i = !cpol;
                repeat (HS) @(negedge clk);
                sclk_i = cpol;
                repeat (HS) @(negedge clk);
            end else begin
                sclk_i = !cpol;
                sdi_drv = rxv[b];
                repeat (HS) @(negedge clk);
                check(sdo == txv[b], "R12 slave sdo cpha1", int'(sdo), int'(txv[b]));
                sclk_i = cpol;
                repeat (HS) @(negedge clk);
            end
        end
        repeat (6) @(negedge clk);
        ss_n = 1'b1;
        repeat (6) @(negedge clk);
        bus_read(2'd0, v);
        check(v[2] == 1'b0, "R11 select high seen", int'(v[2]), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(2'd0, v);
        check(v == 16'h0001, "R1 status reset", int'(v), 1);
        bus_read(2'd3, v);
        check(v == 16'h0000, "R1 control reset", int'(v), 0);
        check(irq == 1'b0, "R1 irq reset", int'(irq), 0);
        check(sclk_o == 1'b0, "R1 sclk reset", int'(sclk_o), 0);

        // R2 control readback, upper bits dropped
        bus_write(2'd3, 16'hFFF4);
        bus_read(2'd3, v);
        check(v == 16'h00F4, "R2 control readback", int'(v), 16'h00F4);
        bus_write(2'd3, 16'h0000);

        // R10 status write ignored
        bus_write(2'd0, 16'hFFFF);
        bus_read(2'd0, v);
        check(v == 16'h0001, "R10 status write ignored", int'(v), 1);

        cmp_on = 1'b1;
        lb_on  = 1'b1;

        // R3 R4 R5 R6 R7 master frames in four modes
        master_frame(1'b0, 1'b0, 0, 1'b0, 8'hA5, 1'b0, 1'b1);
        master_frame(1'b1, 1'b1, 1, 1'b1, 8'h3C, 1'b1, 1'b1);
        master_frame(1'b0, 1'b1, 2, 1'b0, 8'h81, 1'b0, 1'b1);
        master_frame(1'b1, 1'b0, 0, 1'b1, 8'h7E, 1'b1, 1'b1);

        // R8 overwrite without read
        master_frame(1'b0, 1'b0, 1, 1'b1, 8'h12, 1'b0, 1'b0);
        master_frame(1'b0, 1'b0, 1, 1'b1, 8'hC9, 1'b0, 1'b0);
        bus_read(2'd2, v);
        check(v == 16'h00C9, "R8 overwrite data", int'(v), 16'h00C9);

        // R14 byte written during a running frame
        bus_write(2'd3, {8'd0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1});
        bus_write(2'd1, 16'h005A);
        repeat (5) @(negedge clk);
        bus_write(2'd1, 16'h00E1);
        bus_read(2'd0, v);
        check(v[0] == 1'b0 && v[2] == 1'b1, "R14 queued while busy", int'(v[2:0]), 3'b100);
        wait_master_idle();
        bus_read(2'd2, v);
        check(v == 16'h00E1, "R14 second byte received", int'(v), 16'h00E1);

        // slave phase
        cmp_on = 1'b0;
        lb_on  = 1'b0;
        do_reset();
        bus_write(2'd3, {8'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1});
        bus_read(2'd0, v);
        check(v[2] == 1'b0, "R11 select idle", int'(v[2]), 0);
        bus_write(2'd1, 16'h0096);
        slave_frame(1'b0, 1'b0, 8'h96, 8'h4B, 8);
        bus_read(2'd0, v);
        check(v[1:0] == 2'b11, "R12 full and tx taken", int'(v[1:0]), 3);
        bus_read(2'd2, v);
        check(v == 16'h004B, "R12 slave rx cpha0", int'(v), 16'h004B);

        // R13 abort after four bits
        bus_write(2'd1, 16'h00F0);
        slave_frame(1'b0, 1'b0, 8'hF0, 8'h0F, 4);
        bus_read(2'd0, v);
        check(v[1] == 1'b0, "R13 no full after abort", int'(v[1]), 0);
        bus_read(2'd2, v);
        check(v == 16'h004B, "R13 rx kept after abort", int'(v), 16'h004B);

        // R12 R13 clean frame after abort, CPOL=1 CPHA=1
        bus_write(2'd3, {8'd0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1});
        sclk_i = 1'b1;
        repeat (4) @(negedge clk);
        bus_write(2'd1, 16'h00C3);
        slave_frame(1'b1, 1'b1, 8'hC3, 8'h6D, 8);
        bus_read(2'd2, v);
        check(v == 16'h006D, "R12 slave rx cpha1 after abort", int'(v), 16'h006D);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule